// File: doc/BRIEF.md
# Vectored Two-Class Interrupt Controller

This block collects level requests from 64 peripheral sources and drives two active-low request lines toward a processor. One line carries the normal class and the other carries the fast class. Each source has an enable bit, a class bit, a force bit and a 4-bit priority. Normal requests are also filtered by a programmable mask level. A normal-vector register reports the winning normal source and its priority. A fast-vector register reports the highest-numbered fast source.

Software talks to the block over a simple 32-bit register bus. The bus has a word address, a write strobe and write data, and read data comes back in the same cycle. A single source can be enabled or disabled by writing its number to a command register, so the other enable bits need no read-modify-write. Every 64-bit per-source field is split across two words. The low word holds sources 0 to 31 in bits [31:0], and the high word holds sources 32 to 63.

Top module: `intc_vec`

## Requirements
- R1: After reset, all enable, class, force and priority bits are zero and the mask reads 0. Both vector words read 0xFFFFFFFF, and irq_no and fiq_no are high.
- R2: A write to the enable-by-number word (word 2) sets only the enable bit selected by wdata_i[5:0]. A write to the disable-by-number word (word 3) clears only that bit. Bits [31:6] of the write data are ignored. Enables read back at word 5 (sources 0-31) and word 4 (sources 32-63).
- R3: A write to an enable word replaces that half of the enable bits. With both halves at zero, no source is pending and both request lines are high.
- R4: A class bit of 1 (words 7 and 6, low and high) routes a source to the fast class only. A class bit of 0 routes it to the normal class only.
- R5: A source is requested when its src_i bit or its force bit is set. Force bits are read/write at word 21 (low) and word 20 (high).
- R6: The priority word for group x (x = 0..7) sits at word 8+(7-x), which is byte 0x20+4*(7-x). It holds sources 8x+k in bits [4k+3:4k].
- R7: The mask word (word 1) stores wdata_i[4:0] and reads it back zero-extended. If mask bit 4 is set, no normal source is masked. Otherwise a normal source is pending only if its priority is greater than mask[3:0].
- R8: The normal vector (word 16) reads {source, priority} in bits [31:16] and [15:0]. It names the pending normal source with the highest priority, and a tie goes to the higher source number. It reads 0xFFFFFFFF when no normal source is pending. The normal pending bits read at words 23 (low) and 22 (high).
- R9: The fast vector (word 17) reads the highest-numbered pending fast source in bits [31:16], with bits [15:0] zero. It reads 0xFFFFFFFF when no fast source is pending. The fast pending bits read at words 25 (low) and 24 (high).
- R10: irq_no and fiq_no are registered. Each goes low at the first clock edge after a source of its class becomes pending, and goes high at the first edge after none is pending.
- R11: src_i reads at word 19 (low) and word 18 (high). The control word (word 0) and both command words read zero. Writes to read-only words have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| src_i | input | 64 | Level requests from the sources |
| irq_no | output | 1 | Normal-class request, active low |
| fiq_no | output | 1 | Fast-class request, active low |

## Verification
The bench builds the block with its default parameters: 64 sources and 4-bit priorities. At that size every source number can be swept one at a time through the command registers, the class bits and the force bits. Every one of the 16 mask levels, plus the bypass value, is applied with all sources requesting. A fixed arithmetic priority pattern gives many equal-priority ties, so the higher-number tie rule is hit often by both single-source and pseudo-random request patterns.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned WADDR_W = 5;
  typedef logic [WADDR_W-1:0] waddr_t;

  localparam waddr_t A_CTRL      = 5'd0;
  localparam waddr_t A_MASK      = 5'd1;
  localparam waddr_t A_EN_NUM    = 5'd2;
  localparam waddr_t A_DIS_NUM   = 5'd3;
  localparam waddr_t A_EN_HI     = 5'd4;
  localparam waddr_t A_EN_LO     = 5'd5;
  localparam waddr_t A_TYP_HI    = 5'd6;
  localparam waddr_t A_TYP_LO    = 5'd7;
  localparam waddr_t A_PRIO_BASE = 5'd8;
  localparam waddr_t A_NVEC      = 5'd16;
  localparam waddr_t A_FVEC      = 5'd17;
  localparam waddr_t A_SRC_HI    = 5'd18;
  localparam waddr_t A_SRC_LO    = 5'd19;
  localparam waddr_t A_FRC_HI    = 5'd20;
  localparam waddr_t A_FRC_LO    = 5'd21;
  localparam waddr_t A_NPND_HI   = 5'd22;
  localparam waddr_t A_NPND_LO   = 5'd23;
  localparam waddr_t A_FPND_HI   = 5'd24;
  localparam waddr_t A_FPND_LO   = 5'd25;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  waddr_t                    addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [NUM_SRC-1:0]        en_o,
  output logic [NUM_SRC-1:0]        typ_o,
  output logic [NUM_SRC-1:0]        frc_o,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o,
  output logic [PRIO_W:0]           mask_o
);
  localparam int unsigned HALF  = NUM_SRC / 2;
  localparam int unsigned IDX_W = $clog2(NUM_SRC);
  localparam int unsigned FPR   = REG_W / PRIO_W;
  localparam int unsigned NPR   = NUM_SRC / FPR;

  logic [NUM_SRC-1:0] en_q, typ_q, frc_q;
  logic [PRIO_W:0]    mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MASK:    mask_q <= wdata_i[PRIO_W:0];
        A_EN_NUM:  en_q[wdata_i[IDX_W-1:0]] <= 1'b1;
        A_DIS_NUM: en_q[wdata_i[IDX_W-1:0]] <= 1'b0;
        A_EN_HI:   en_q[NUM_SRC-1:HALF]  <= wdata_i[HALF-1:0];
        A_EN_LO:   en_q[HALF-1:0]        <= wdata_i[HALF-1:0];
        A_TYP_HI:  typ_q[NUM_SRC-1:HALF] <= wdata_i[HALF-1:0];
        A_TYP_LO:  typ_q[HALF-1:0]       <= wdata_i[HALF-1:0];
        A_FRC_HI:  frc_q[NUM_SRC-1:HALF] <= wdata_i[HALF-1:0];
        A_FRC_LO:  frc_q[HALF-1:0]       <= wdata_i[HALF-1:0];
        default: ;
      endcase
    end
  end

  // group g sits at descending word addresses
  for (genvar g = 0; g < NPR; g++) begin : g_prio
    localparam waddr_t PADDR = waddr_t'(int'(A_PRIO_BASE) + int'(NPR) - 1 - g);
    logic [REG_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          word_q <= '0;
      else if (we_i && (addr_i == PADDR))   word_q <= wdata_i;
    end
    assign prio_o[g*REG_W +: REG_W] = word_q;
  end

  assign en_o   = en_q;
  assign typ_o  = typ_q;
  assign frc_o  = frc_q;
  assign mask_o = mask_q;

  assert_en_num_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN_NUM) |=>
      (en_q[$past(wdata_i[IDX_W-1:0])] && ($countones(en_q ^ $past(en_q)) <= 1)));

  assert_dis_num_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIS_NUM) |=>
      (!en_q[$past(wdata_i[IDX_W-1:0])] && ($countones(en_q ^ $past(en_q)) <= 1)));
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]        src_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC-1:0]        typ_i,
  input  logic [NUM_SRC-1:0]        frc_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W:0]           mask_i,
  output logic [NUM_SRC-1:0]        npend_o,
  output logic [NUM_SRC-1:0]        fpend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PRIO_W-1:0] lvl;
    logic              live, above;
    assign lvl        = prio_i[i*PRIO_W +: PRIO_W];
    assign live       = (src_i[i] | frc_i[i]) & en_i[i];
    // top mask bit set means no level is masked
    assign above      = mask_i[PRIO_W] | (lvl > mask_i[PRIO_W-1:0]);
    assign npend_o[i] = live & ~typ_i[i] & above;
    assign fpend_o[i] = live & typ_i[i];
  end
endmodule

// File: rtl/intc_nvec_arb.sv
module intc_nvec_arb #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         lvl_o
);
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [PRIO_W-1:0] lvl;

  // ascending scan with >= hands ties to the higher index
  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!hit || (prio_i[i*PRIO_W +: PRIO_W] >= lvl))) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        lvl = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign valid_o = hit;
  assign idx_o   = idx;
  assign lvl_o   = lvl;
endmodule

// File: rtl/intc_hi_enc.sv
module intc_hi_enc #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (vec_i[i]) idx = IDX_W'(i);
    end
  end

  assign valid_o = |vec_i;
  assign idx_o   = idx;
endmodule

// File: rtl/intc_vec.sv
module intc_vec
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_no,
  output logic               fiq_no
);
  localparam int unsigned HALF  = NUM_SRC / 2;
  localparam int unsigned IDX_W = $clog2(NUM_SRC);
  localparam int unsigned FPR   = REG_W / PRIO_W;
  localparam int unsigned NPR   = NUM_SRC / FPR;
  localparam int unsigned HW    = REG_W / 2;

  logic [NUM_SRC-1:0]        en, typ, frc, npend, fpend;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic [PRIO_W:0]           mask;
  logic                      n_valid, f_valid;
  logic [IDX_W-1:0]          n_idx, f_idx;
  logic [PRIO_W-1:0]         n_lvl;
  logic                      irq_q, fiq_q;

  intc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .en_o    (en),
    .typ_o   (typ),
    .frc_o   (frc),
    .prio_o  (prio),
    .mask_o  (mask)
  );

  intc_pend #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) pend_i (
    .src_i   (src_i),
    .en_i    (en),
    .typ_i   (typ),
    .frc_i   (frc),
    .prio_i  (prio),
    .mask_i  (mask),
    .npend_o (npend),
    .fpend_o (fpend)
  );

  intc_nvec_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) narb_i (
    .pend_i  (npend),
    .prio_i  (prio),
    .valid_o (n_valid),
    .idx_o   (n_idx),
    .lvl_o   (n_lvl)
  );

  intc_hi_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) fenc_i (
    .vec_i   (fpend),
    .valid_o (f_valid),
    .idx_o   (f_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b1;
      fiq_q <= 1'b1;
    end else begin
      irq_q <= ~(|npend);
      fiq_q <= ~(|fpend);
    end
  end

  assign irq_no = irq_q;
  assign fiq_no = fiq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MASK:    rdata_o = {{(REG_W-PRIO_W-1){1'b0}}, mask};
      A_EN_HI:   rdata_o = en[NUM_SRC-1:HALF];
      A_EN_LO:   rdata_o = en[HALF-1:0];
      A_TYP_HI:  rdata_o = typ[NUM_SRC-1:HALF];
      A_TYP_LO:  rdata_o = typ[HALF-1:0];
      A_NVEC:    rdata_o = n_valid ? {{(HW-IDX_W){1'b0}}, n_idx, {(HW-PRIO_W){1'b0}}, n_lvl} : '1;
      A_FVEC:    rdata_o = f_valid ? {{(HW-IDX_W){1'b0}}, f_idx, {HW{1'b0}}} : '1;
      A_SRC_HI:  rdata_o = src_i[NUM_SRC-1:HALF];
      A_SRC_LO:  rdata_o = src_i[HALF-1:0];
      A_FRC_HI:  rdata_o = frc[NUM_SRC-1:HALF];
      A_FRC_LO:  rdata_o = frc[HALF-1:0];
      A_NPND_HI: rdata_o = npend[NUM_SRC-1:HALF];
      A_NPND_LO: rdata_o = npend[HALF-1:0];
      A_FPND_HI: rdata_o = fpend[NUM_SRC-1:HALF];
      A_FPND_LO: rdata_o = fpend[HALF-1:0];
      default: begin
        for (int g = 0; g < NPR; g++) begin
          if (addr_i == waddr_t'(int'(A_PRIO_BASE) + int'(NPR) - 1 - g))
            rdata_o = prio[g*REG_W +: REG_W];
        end
      end
    endcase
  end

  assert_irq_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_no == !$past(n_valid)));

  assert_fiq_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fiq_no == !$past(f_valid)));

  assert_vec_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_valid |-> (npend[n_idx] && !typ[n_idx]));

  assert_off_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> (irq_no && fiq_no));
endmodule

// File: tb/intc_vec_tb_top.sv
module intc_vec_tb_top;
  import intc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni, we;
  waddr_t      addr;
  logic [31:0] wdata, rdata;
  logic [63:0] src;
  logic        irq_n, fiq_n;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_en, m_typ, m_frc;
  logic [3:0]  m_p [64];
  logic [4:0]  m_mask;

  always #10 clk = ~clk;

  intc_vec dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .src_i   (src),
    .irq_no  (irq_n),
    .fiq_no  (fiq_n)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(waddr_t a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rchk(string tag, waddr_t a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  function automatic logic [63:0] npnd_m();
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++)
      r[i] = (src[i] | m_frc[i]) & m_en[i] & ~m_typ[i] & (m_mask[4] | (m_p[i] > m_mask[3:0]));
    return r;
  endfunction

  function automatic logic [63:0] fpnd_m();
    return (src | m_frc) & m_en & m_typ;
  endfunction

  function automatic logic [31:0] nvec_m();
    logic [63:0] p = npnd_m();
    logic [31:0] r = '1;
    int best = -1;
    for (int i = 0; i < 64; i++)
      if (p[i] && (best < 0 || m_p[i] >= m_p[best])) best = i;
    if (best >= 0) r = (32'(best) << 16) | 32'(m_p[best]);
    return r;
  endfunction

  function automatic logic [31:0] fvec_m();
    logic [63:0] p = fpnd_m();
    logic [31:0] r = '1;
    for (int i = 0; i < 64; i++)
      if (p[i]) r = 32'(i) << 16;
    return r;
  endfunction

  task automatic check_state(string tag);
    logic [63:0] np = npnd_m();
    logic [63:0] fp = fpnd_m();
    rchk({tag, " R8 npnd lo"}, A_NPND_LO, np[31:0]);
    rchk({tag, " R8 npnd hi"}, A_NPND_HI, np[63:32]);
    rchk({tag, " R9 fpnd lo"}, A_FPND_LO, fp[31:0]);
    rchk({tag, " R9 fpnd hi"}, A_FPND_HI, fp[63:32]);
    rchk({tag, " R8 nvec"}, A_NVEC, nvec_m());
    rchk({tag, " R9 fvec"}, A_FVEC, fvec_m());
    chk({tag, " R10 irq_n"}, 32'(irq_n), 32'(~|np));
    chk({tag, " R10 fiq_n"}, 32'(fiq_n), 32'(~|fp));
  endtask

  task automatic put_prio();
    for (int x = 0; x < 8; x++) begin
      logic [31:0] w;
      for (int k = 0; k < 8; k++) w[4*k +: 4] = m_p[8*x+k];
      wr(waddr_t'(8 + 7 - x), w);
    end
  endtask

  task automatic put_en(logic [63:0] v);
    m_en = v; wr(A_EN_LO, v[31:0]); wr(A_EN_HI, v[63:32]);
  endtask

  task automatic put_typ(logic [63:0] v);
    m_typ = v; wr(A_TYP_LO, v[31:0]); wr(A_TYP_HI, v[63:32]);
  endtask

  task automatic put_frc(logic [63:0] v);
    m_frc = v; wr(A_FRC_LO, v[31:0]); wr(A_FRC_HI, v[63:32]);
  endtask

  task automatic put_src(logic [63:0] v);
    @(negedge clk);
    src = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] lf;
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0; src = '0;
    m_en = '0; m_typ = '0; m_frc = '0; m_mask = '0;
    for (int i = 0; i < 64; i++) m_p[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 32'd1);
    chk("R1 fiq_n", 32'(fiq_n), 32'd1);
    rchk("R1 en lo", A_EN_LO, '0);
    rchk("R1 en hi", A_EN_HI, '0);
    rchk("R1 typ lo", A_TYP_LO, '0);
    rchk("R1 typ hi", A_TYP_HI, '0);
    rchk("R1 frc lo", A_FRC_LO, '0);
    rchk("R1 frc hi", A_FRC_HI, '0);
    rchk("R1 mask", A_MASK, '0);
    for (int w = 8; w < 16; w++) rchk("R1 prio", waddr_t'(w), '0);
    rchk("R1 nvec", A_NVEC, '1);
    rchk("R1 fvec", A_FVEC, '1);

    // R2 enable / disable by number, upper data bits are junk
    for (int n = 0; n < 64; n++) begin
      wr(A_EN_NUM, 32'hA5A5_0000 | 32'(n));
      m_en[n] = 1'b1;
      rchk("R2 set lo", A_EN_LO, m_en[31:0]);
      rchk("R2 set hi", A_EN_HI, m_en[63:32]);
    end
    for (int n = 0; n < 64; n += 3) begin
      wr(A_DIS_NUM, 32'h5A5A_FF00 | 32'(n));
      m_en[n] = 1'b0;
      rchk("R2 clr lo", A_EN_LO, m_en[31:0]);
      rchk("R2 clr hi", A_EN_HI, m_en[63:32]);
    end

    // R11 read-only words and zero-reading words
    put_src(64'h0123_4567_89AB_CDEF);
    wr(A_SRC_LO, 32'hFFFF_FFFF);
    wr(A_SRC_HI, 32'h0);
    rchk("R11 src lo", A_SRC_LO, 32'h89AB_CDEF);
    rchk("R11 src hi", A_SRC_HI, 32'h0123_4567);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rchk("R11 ctrl", A_CTRL, '0);
    rchk("R11 en_num", A_EN_NUM, '0);
    rchk("R11 dis_num", A_DIS_NUM, '0);
    wr(A_NVEC, 32'h0);
    wr(A_FVEC, 32'h0);
    rchk("R11 nvec ro", A_NVEC, '1);
    rchk("R11 fvec ro", A_FVEC, '1);

    // R3 whole-word enables, zero shuts everything off
    wr(A_MASK, 32'hFFFF_FFFF); m_mask = 5'h1F;
    put_en('1);
    put_src('1);
    check_state("R3 all on");
    put_en('0);
    check_state("R3 all off");
    rchk("R3 en lo", A_EN_LO, '0);
    rchk("R3 en hi", A_EN_HI, '0);

    // R6 priority layout, R8 single-source sweep
    for (int i = 0; i < 64; i++) m_p[i] = 4'((i * 7 + 3) % 16);
    put_prio();
    for (int x = 0; x < 8; x++) begin
      logic [31:0] w;
      for (int k = 0; k < 8; k++) w[4*k +: 4] = m_p[8*x+k];
      rchk("R6 prio word", waddr_t'(8 + 7 - x), w);
    end
    put_en('1);
    for (int n = 0; n < 64; n++) begin
      put_src(64'd1 << n);
      check_state("R6 single");
    end
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int t = 0; t < 48; t++) begin
      lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
      put_src(lf & (lf >> 3));
      check_state("R8 pattern");
    end

    // R7 mask sweep with all sources requesting
    put_src('1);
    for (int m = 0; m <= 16; m++) begin
      m_mask = (m == 16) ? 5'h1F : 5'(m);
      wr(A_MASK, (m == 16) ? 32'hFFFF_FFE0 | 32'h1F : 32'(m));
      rchk("R7 mask rb", A_MASK, 32'(m_mask));
      check_state("R7 level");
    end

    // R4 / R9 class routing
    for (int n = 0; n < 64; n++) begin
      put_typ(64'd1 << n);
      check_state("R4 one fast");
    end
    put_typ(64'hF0F0_0F0F_3C3C_C3C3);
    rchk("R4 typ lo", A_TYP_LO, 32'h3C3C_C3C3);
    rchk("R4 typ hi", A_TYP_HI, 32'hF0F0_0F0F);
    for (int t = 0; t < 8; t++) begin
      lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
      put_src(lf);
      check_state("R9 mixed");
    end
    put_typ('0);

    // R5 force bits request without src_i
    put_src('0);
    check_state("R5 idle");
    for (int n = 0; n < 64; n += 5) begin
      put_frc(64'd1 << n);
      rchk("R5 frc lo", A_FRC_LO, m_frc[31:0]);
      rchk("R5 frc hi", A_FRC_HI, m_frc[63:32]);
      check_state("R5 forced");
    end
    put_frc('0);

    // R10 output latency: one edge after pending changes
    put_src('0);
    @(negedge clk);
    chk("R10 irq idle", 32'(irq_n), 32'd1);
    src = 64'd1 << 40;
    #1 chk("R10 irq before edge", 32'(irq_n), 32'd1);
    @(negedge clk);
    chk("R10 irq after edge", 32'(irq_n), 32'd0);
    src = '0;
    #1 chk("R10 irq hold", 32'(irq_n), 32'd0);
    @(negedge clk);
    chk("R10 irq release", 32'(irq_n), 32'd1);
    put_typ(64'd1 << 9);
    @(negedge clk);
    src = 64'd1 << 9;
    #1 chk("R10 fiq before edge", 32'(fiq_n), 32'd1);
    @(negedge clk);
    chk("R10 fiq after edge", 32'(fiq_n), 32'd0);
    chk("R10 irq quiet", 32'(irq_n), 32'd1);
    src = '0;
    @(negedge clk);
    chk("R10 fiq release", 32'(fiq_n), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule